// File: doc/BRIEF.md
# Configurable UART Receive Engine

This block turns an asynchronous serial line into received words. A baud generator outside the block supplies a pulse at sixteen times the bit rate. The engine uses that pulse to find start bits, sample each bit at its centre and check the stop bits. Each finished word goes into a four-entry receive queue together with its parity and framing tags. Sticky status outputs report parity errors, framing errors, overflow and line break until they are cleared.

Several things are set by inputs: the character format, the line polarity, how many stop bits are checked, the moment a break is reported, and what the receiver does when the queue is full. Deasserting the receive enable resets only the receive state machine and the break counter. Data already queued and the status flags are left as they are, so software can drain the queue after stopping reception.

Top module: `uart_rx_engine`

## Requirements
- R1: `fmt_i` selects the character: 0000 gives 8 data bits; 0001 gives 7 data bits; 0010 and 0011 give 8 data bits plus a parity bit; 0100 gives 9 data bits. Any other value behaves as 0000. Bits arrive LSB first, after one start bit (low). They are right-justified in `rd_data_o`, and unused upper bits read 0.
- R2: In format 0010 the ones count over the 8 data bits and the parity bit must be odd. In format 0011 it must be even. A mismatch sets the word's `rd_perr_o` tag and the sticky `perr_o`. The parity bit itself is not stored: `rd_data_o[8]` reads 0.
- R3: In format 0100 the ninth received bit is stored in `rd_data_o[8]`. A value of 1 marks an address word.
- R4: When `rx_inv_i` is 1 the pin is inverted before any other processing, so the idle level at the pin is low.
- R5: Each start bit is checked at its middle, 8 ticks after the first low sample. If the line is high there, the receiver treats it as a glitch and stores nothing.
- R6: `stop_sel_i` sets which stop bits are checked: 00 checks one stop bit at its middle; 01 checks 1.5, with a second sample 12 ticks after the first; 10 checks 2, with a second sample 16 ticks after the first; 11 checks only one. A low sample on any checked stop bit sets the word's `rd_ferr_o` tag and `ferr_o`, and the word is still stored.
- R7: A break is the line held low for 11 bit periods (176 ticks). With `brk_early_i` at 1, `brk_o` sets as soon as the count is reached. With `brk_early_i` at 0, it sets on the first high sample after the count is reached. A shorter low never sets it.
- R8: With `keep_sync_i` at 1, a word that completes while the queue is full is dropped and `ovf_o` sets. Queued words are not overwritten, and reception carries on with the next frame.
- R9: With `keep_sync_i` at 0, a word that completes while the queue is full is held and `ovf_o` sets. The receiver then ignores the line until a queue slot frees up. The held word then enters the queue, and frames sent during the wait are lost.
- R10: While `rx_en_i` is 0, the receive state machine and the break counter are held in reset and any frame in progress is abandoned. Queued words and the status flags are kept.
- R11: The queue holds 4 words. `empty_o` and `full_o` report its state, and `rd_*` show the oldest word. `pop_i` removes that word, and has no effect while the queue is empty.
- R12: `perr_o`, `ferr_o`, `ovf_o` and `brk_o` stay set until `flags_clr_i` is pulsed.
- R13: After reset the queue is empty, `full_o` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_i | input | 1 | Serial input pin |
| rx_inv_i | input | 1 | Invert the pin |
| fmt_i | input | 4 | Character format |
| stop_sel_i | input | 2 | Stop-bit check selection |
| keep_sync_i | input | 1 | 1: drop on overflow and keep receiving; 0: hold and stall |
| brk_early_i | input | 1 | 1: flag break at the count; 0: flag at the end of the break |
| pop_i | input | 1 | Remove the oldest queued word |
| flags_clr_i | input | 1 | Clear the sticky flags |
| rd_data_o | output | 9 | Oldest queued data |
| rd_perr_o | output | 1 | Parity tag of the oldest word |
| rd_ferr_o | output | 1 | Framing tag of the oldest word |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| perr_o | output | 1 | Sticky parity error |
| ferr_o | output | 1 | Sticky framing error |
| ovf_o | output | 1 | Sticky overflow |
| brk_o | output | 1 | Sticky break |

## Verification
Random frames use random formats, data, parity bits, stop settings and both polarities. A wrong bit order, a misplaced ninth bit, a swapped parity sense or a missed inversion therefore shows up as a data or tag mismatch.

Directed line shapes test the timing:
- A short low pulse tests start validation at mid-bit.
- A low window placed inside the second stop bit tells the four stop settings apart.
- Low periods just below and above the break length tell the two break timing modes apart.

Overflow is tested by sending six frames into an undrained queue. Which words survive distinguishes the drop policy from the hold policy. A frame cut short by disabling reception tests that the queue and the flags survive while the shifter restarts cleanly.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  typedef struct packed {
    logic [8:0] data;
    logic       perr;
    logic       ferr;
  } rx_word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_STOP2, ST_HOLD
  } rx_state_e;

  localparam logic [3:0] FMT_D7   = 4'b0001;
  localparam logic [3:0] FMT_ODD  = 4'b0010;
  localparam logic [3:0] FMT_EVEN = 4'b0011;
  localparam logic [3:0] FMT_D9   = 4'b0100;

  localparam logic [1:0] STP_HALF = 2'b01;
  localparam logic [1:0] STP_TWO  = 2'b10;
endpackage

// File: rtl/uart_rx_brk.sv
`timescale 1ns/1ps
module uart_rx_brk #(
  parameter int unsigned OSR      = 16,
  parameter int unsigned BRK_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  input  logic early_i,
  output logic brk_evt_o
);
  localparam int unsigned THR  = OSR * BRK_BITS;
  localparam int unsigned CNTW = $clog2(THR + 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (tick_i) begin
      if (line_i)           cnt_q <= '0;
      else if (cnt_q != CNTW'(THR)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (early_i) brk_evt_o = en_i && tick_i && !line_i && (cnt_q == CNTW'(THR - 1));
    else         brk_evt_o = en_i && tick_i &&  line_i && (cnt_q == CNTW'(THR));
  end
endmodule

// File: rtl/uart_rx_shift.sv
`timescale 1ns/1ps
module uart_rx_shift
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [3:0] fmt_i,
  input  logic [1:0] stop_sel_i,
  input  logic       keep_sync_i,
  input  logic       full_i,
  output logic       push_o,
  output rx_word_t   word_o,
  output logic       ovf_evt_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] LIM_MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LIM_BIT  = CW'(OSR - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(OSR * 3 / 4 - 1);

  rx_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q;
  logic [8:0]    sh_q;
  logic          ferr_q, armed_q;
  rx_word_t      hold_q, word_c;

  logic [3:0]    last_idx;
  logic [CW-1:0] lim;
  logic          par_fmt, multi_stop, smp, fin;

  always_comb begin
    par_fmt    = (fmt_i == FMT_ODD) || (fmt_i == FMT_EVEN);
    last_idx   = (fmt_i == FMT_D7) ? 4'd6 : ((par_fmt || fmt_i == FMT_D9) ? 4'd8 : 4'd7);
    multi_stop = (stop_sel_i == STP_TWO) || (stop_sel_i == STP_HALF);
    case (state_q)
      ST_START: lim = LIM_MID;
      ST_STOP2: lim = (stop_sel_i == STP_HALF) ? LIM_HALF : LIM_BIT;
      default:  lim = LIM_BIT;
    endcase
    smp = tick_i && (cnt_q == lim);
    fin = smp && ((state_q == ST_STOP && !multi_stop) || state_q == ST_STOP2);
    word_c.data = par_fmt ? {1'b0, sh_q[7:0]} : sh_q;
    word_c.perr = (fmt_i == FMT_ODD) ? ~(^sh_q) : ((fmt_i == FMT_EVEN) ? ^sh_q : 1'b0);
    word_c.ferr = ferr_q | ~line_i;
    push_o    = en_i && !full_i && (fin || state_q == ST_HOLD);
    word_o    = (state_q == ST_HOLD) ? hold_q : word_c;
    ovf_evt_o = en_i && fin && full_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      ferr_q <= 1'b0; armed_q <= 1'b0; hold_q <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0;
      ferr_q <= 1'b0; armed_q <= 1'b0;
    end else begin
      if (tick_i && state_q != ST_IDLE && state_q != ST_HOLD)
        cnt_q <= smp ? '0 : cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: if (tick_i) begin
          if (line_i) armed_q <= 1'b1;
          else if (armed_q) begin state_q <= ST_START; cnt_q <= '0; end
        end
        ST_START: if (smp) begin
          if (line_i) begin state_q <= ST_IDLE; armed_q <= 1'b1; end  // glitch
          else begin state_q <= ST_DATA; idx_q <= '0; sh_q <= '0; ferr_q <= 1'b0; end
        end
        ST_DATA: if (smp) begin
          sh_q[idx_q] <= line_i;
          if (idx_q == last_idx) state_q <= ST_STOP;
          else idx_q <= idx_q + 1'b1;
        end
        ST_STOP: if (smp && multi_stop) begin
          ferr_q  <= ferr_q | ~line_i;
          state_q <= ST_STOP2;
        end
        ST_HOLD: if (!full_i) begin state_q <= ST_IDLE; armed_q <= 1'b0; end
        default: ;
      endcase
      if (fin) begin
        armed_q <= 1'b0;  // wait for high before next start
        if (full_i && !keep_sync_i) begin hold_q <= word_c; state_q <= ST_HOLD; end
        else state_q <= ST_IDLE;
      end
    end
  end

  a_r10_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);
  a_r9_hold_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD |=> (state_q == ST_HOLD || state_q == ST_IDLE));
  a_r8_no_hold_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_sync_i && state_q != ST_HOLD) |=> state_q != ST_HOLD);
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  rx_word_t wdata_i,
  input  logic     pop_i,
  output rx_word_t rdata_o,
  output logic     empty_o,
  output logic     full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_word_t      mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) if (do_push) mem_q[wp_q] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r11_push_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r11_pop_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pop_i && !push_i) |=> !full_o);
endmodule

// File: rtl/uart_rx_engine.sv
`timescale 1ns/1ps
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR      = 16,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned BRK_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       rx_inv_i,
  input  logic [3:0] fmt_i,
  input  logic [1:0] stop_sel_i,
  input  logic       keep_sync_i,
  input  logic       brk_early_i,
  input  logic       pop_i,
  input  logic       flags_clr_i,
  output logic [8:0] rd_data_o,
  output logic       rd_perr_o,
  output logic       rd_ferr_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       ovf_o,
  output logic       brk_o
);
  logic     rx_m_q, line_q;
  logic     push, ovf_evt, brk_evt;
  rx_word_t wword, rword;

  // invert first, then synchronize; reset to idle level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin rx_m_q <= 1'b1; line_q <= 1'b1; end
    else begin rx_m_q <= rx_i ^ rx_inv_i; line_q <= rx_m_q; end
  end

  uart_rx_shift #(.OSR(OSR)) u_shift (
    .clk_i, .rst_ni, .en_i(rx_en_i), .tick_i, .line_i(line_q), .fmt_i, .stop_sel_i,
    .keep_sync_i, .full_i(full_o), .push_o(push), .word_o(wword), .ovf_evt_o(ovf_evt));

  uart_rx_brk #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_brk (
    .clk_i, .rst_ni, .en_i(rx_en_i), .tick_i, .line_i(line_q), .early_i(brk_early_i),
    .brk_evt_o(brk_evt));

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(wword), .pop_i,
    .rdata_o(rword), .empty_o, .full_o);

  assign rd_data_o = rword.data;
  assign rd_perr_o = rword.perr;
  assign rd_ferr_o = rword.ferr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_o <= 1'b0; ferr_o <= 1'b0; ovf_o <= 1'b0; brk_o <= 1'b0;
    end else begin
      perr_o <= (perr_o && !flags_clr_i) || (push && wword.perr);
      ferr_o <= (ferr_o && !flags_clr_i) || (push && wword.ferr);
      ovf_o  <= (ovf_o  && !flags_clr_i) || ovf_evt;
      brk_o  <= (brk_o  && !flags_clr_i) || brk_evt;
    end
  end

  a_r7_late_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_evt && !brk_early_i) |-> line_q);
  a_r8_ovf_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(full_o));
endmodule

// File: tb/uart_rx_engine_test.sv
`timescale 1ns/1ps
module uart_rx_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, tick = 1'b0, rx = 1'b1, inv = 1'b0;
  logic [3:0] fmt = 4'd0;
  logic [1:0] stop_sel = 2'd0;
  logic keep_sync = 1'b1, brk_early = 1'b1, pop = 1'b0, clr = 1'b0;
  logic [8:0] rd_data;
  logic rd_perr, rd_ferr, empty, full, perr, ferr, ovf, brk;
  int checks = 0, errors = 0, tdiv = 0;

  uart_rx_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .tick_i(tick), .rx_i(rx),
    .rx_inv_i(inv), .fmt_i(fmt), .stop_sel_i(stop_sel), .keep_sync_i(keep_sync),
    .brk_early_i(brk_early), .pop_i(pop), .flags_clr_i(clr), .rd_data_o(rd_data),
    .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .empty_o(empty), .full_o(full),
    .perr_o(perr), .ferr_o(ferr), .ovf_o(ovf), .brk_o(brk));

  always #4 clk = ~clk;
  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 2);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic drive(input logic lvl, input int n);
    rx = lvl ^ inv;
    wait_ticks(n);
  endtask

  task automatic send(input logic [8:0] bits, input int n, input int hi, input int lo, input int tail);
    drive(1'b0, 16);
    for (int k = 0; k < n; k++) drive(bits[k], 16);
    if (hi > 0) drive(1'b1, hi);
    if (lo > 0) drive(1'b0, lo);
    drive(1'b1, tail);
  endtask

  task automatic pop_chk(input string req, input logic [8:0] d, input logic pe, input logic fe);
    chk({req, " not empty"}, empty, 0);
    chk({req, " data"}, rd_data, d);
    chk({req, " perr tag"}, rd_perr, pe);
    chk({req, " ferr tag"}, rd_ferr, fe);
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
  endtask

  task automatic clear_flags();
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  function automatic int nbits(input logic [3:0] f);
    if (f == 4'd1) return 7;
    if (f == 4'd2 || f == 4'd3 || f == 4'd4) return 9;
    return 8;
  endfunction

  function automatic logic [8:0] frame_bits(input logic [3:0] f, input logic [8:0] d, input logic p);
    if (f == 4'd1) return {2'b0, d[6:0]};
    if (f == 4'd2 || f == 4'd3) return {p, d[7:0]};
    if (f == 4'd4) return d;
    return {1'b0, d[7:0]};
  endfunction

  function automatic logic [8:0] exp_data(input logic [3:0] f, input logic [8:0] d);
    if (f == 4'd1) return {2'b0, d[6:0]};
    if (f == 4'd4) return d;
    return {1'b0, d[7:0]};
  endfunction

  function automatic logic exp_perr(input logic [3:0] f, input logic [8:0] d, input logic p);
    if (f == 4'd2) return ~(^d[7:0] ^ p);
    if (f == 4'd3) return ^d[7:0] ^ p;
    return 1'b0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1f3a);
    repeat (5) @(negedge clk);
    // R13 reset state
    chk("R13 empty", empty, 1); chk("R13 full", full, 0);
    chk("R13 flags", {perr, ferr, ovf, brk}, 0);
    rst_n = 1'b1; @(negedge clk); rx_en = 1'b1; wait_ticks(20);

    // R5 glitch, R11 pop on empty
    drive(1'b0, 4); drive(1'b1, 30);
    chk("R5 glitch stored nothing", empty, 1);
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
    chk("R11 pop on empty", {empty, full}, 2'b10);

    // R6 stop checking
    stop_sel = 2'b10; send(9'h0A5, 8, 21, 6, 20);
    chk("R6 ferr flag two stops", ferr, 1);
    pop_chk("R6 two stops checked", 9'h0A5, 0, 1);
    clear_flags(); chk("R12 clear ferr", ferr, 0);
    stop_sel = 2'b11; send(9'h0A5, 8, 21, 6, 20);
    pop_chk("R6 one of two checked", 9'h0A5, 0, 0);
    stop_sel = 2'b01; send(9'h05C, 8, 17, 6, 20);
    pop_chk("R6 one and half checked", 9'h05C, 0, 1);
    stop_sel = 2'b00; send(9'h05C, 8, 17, 6, 20);
    pop_chk("R6 single checked", 9'h05C, 0, 0);
    send(9'h03C, 8, 0, 16, 24);
    pop_chk("R6 low stop kept", 9'h03C, 0, 1);
    clear_flags();

    // R7 break
    brk_early = 1'b1;
    drive(1'b0, 165); drive(1'b1, 20);
    chk("R7 short low no break", brk, 0);
    pop_chk("R7 short low frame", 9'h000, 0, 1);
    drive(1'b0, 180);
    chk("R7 early break", brk, 1);
    drive(1'b1, 20);
    pop_chk("R7 early break frame", 9'h000, 0, 1);
    clear_flags(); brk_early = 1'b0;
    drive(1'b0, 185);
    chk("R7 late not yet", brk, 0);
    drive(1'b1, 10);
    chk("R7 late at rising", brk, 1);
    pop_chk("R7 late break frame", 9'h000, 0, 1);
    clear_flags();
    chk("R12 clear all", {perr, ferr, ovf, brk}, 0);

    // R8 drop policy, R11 full
    keep_sync = 1'b1;
    for (int i = 0; i < 6; i++) begin
      send(9'h010 + 9'(i), 8, 16, 0, 6);
      if (i < 4) chk("R11 full after pushes", full, (i == 3));
    end
    chk("R8 ovf flag", ovf, 1);
    for (int i = 0; i < 4; i++) pop_chk("R8 stored words kept", 9'h010 + 9'(i), 0, 0);
    chk("R8 dropped words", empty, 1);
    send(9'h077, 8, 16, 0, 6);
    pop_chk("R8 in sync after overflow", 9'h077, 0, 0);
    clear_flags();

    // R9 hold policy
    keep_sync = 1'b0;
    for (int i = 0; i < 6; i++) send(9'h020 + 9'(i), 8, 16, 0, 6);
    chk("R9 ovf flag", ovf, 1);
    for (int i = 0; i < 5; i++) pop_chk("R9 held word follows", 9'h020 + 9'(i), 0, 0);
    chk("R9 frame during stall lost", empty, 1);
    keep_sync = 1'b1; clear_flags();

    // R10 enable clear
    fmt = 4'd2;
    send({1'b0, 8'h5A}, 9, 16, 0, 6);
    chk("R2 perr flag", perr, 1);
    drive(1'b0, 16); drive(1'b1, 16); drive(1'b0, 16);
    rx_en = 1'b0; wait_ticks(10); drive(1'b1, 4); rx_en = 1'b1; wait_ticks(4);
    chk("R10 flag kept", perr, 1);
    chk("R10 queue kept", {empty, rd_data}, {1'b0, 9'h05A});
    send({1'b1, 8'h96}, 9, 16, 0, 6);
    pop_chk("R10 old word", 9'h05A, 1, 0);
    pop_chk("R10 clean frame after enable", 9'h096, 0, 0);
    chk("R10 aborted frame not stored", empty, 1);
    clear_flags();

    // random frames: R1 R2 R3 R4
    for (int i = 0; i < 40; i++) begin
      logic [8:0] d;
      logic p;
      logic [1:0] ss;
      string req;
      int hi;
      if (i % 10 == 0) begin inv = (i / 10) % 2; rx = 1'b1 ^ inv; wait_ticks(20); end
      fmt = 4'($urandom % 5); d = 9'($urandom); p = 1'($urandom);
      ss = 2'($urandom); stop_sel = ss;
      hi = (ss == 2'b10) ? 32 : ((ss == 2'b01) ? 24 : 16);
      if (inv) req = "R4 inverted";
      else if (fmt == 4'd4) req = "R3 nine bit";
      else if (fmt == 4'd2 || fmt == 4'd3) req = "R2 parity";
      else req = "R1 format";
      send(frame_bits(fmt, d, p), nbits(fmt), hi, 0, 6);
      pop_chk(req, exp_data(fmt, d), exp_perr(fmt, d, p), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule